// File: doc/BRIEF.md
# Address Translation Privilege Selector

This block sits in front of a page-table walker. For each memory access it decides which privilege mode governs the access and whether the access is translated. It looks at the access kind, the privilege level the core is running at, a modify-privilege control bit with its saved previous-privilege field, the translation-mode field and a debug-mode flag.

When the access runs in machine mode, it bypasses translation. The physical address is then the incoming address with every bit at or above XLEN cleared. In every other mode the block raises a walk request and hands the effective mode to the walker. It then joins the walker's page-aligned result with the page offset of the incoming address. The walk itself and the permission checks are done elsewhere.

The request to the walker is combinational. The effective mode, bypass flag and physical address pass through an output stage. By default this stage is a register with one cycle of latency. A parameter can make it a plain wire.

Top module: `xlat_priv_sel`

## Requirements
- R1: For a data access (access kind not 0), the effective mode is taken from `prev_priv` when `mod_priv` is 1 and `dbg_mode` is 0. Otherwise it is `cur_priv`. Access kinds are 0 fetch, 1 load, 2 store, and 3, which is treated as a data access. Privilege codes are 0 user, 1 supervisor and 3 machine.
- R2: For an instruction fetch (access kind 0), the effective mode is always `cur_priv`, whatever the value of `mod_priv`.
- R3: While `dbg_mode` is 1, the effective mode is `cur_priv` for every access kind, even when `mod_priv` is 1.
- R4: When `vm_mode` equals 0 (no translation), the effective mode is machine (3) and `bypass` is 1, whatever the other inputs are.
- R5: When the effective mode is machine, `bypass` is 1, `walk_req` is 0, and `paddr` equals `vaddr` with bits XLEN and above forced to 0.
- R6: When the effective mode is not machine:
  - `walk_req` is 1 and `walk_mode` equals the effective mode, both in the same cycle as the inputs.
  - `bypass` is 0.
  - `paddr` takes bits AW-1..12 from `walk_pbase` and bits 11..0 from `vaddr`. The low 12 bits of `walk_pbase` have no effect.
- R7: With REG_OUT=1, `eff_mode`, `bypass` and `paddr` change one clock edge after the inputs change. While `rst` is high they hold machine mode (3), bypass 1 and an address of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 data |
| cur_priv | input | 2 | Current privilege level |
| mod_priv | input | 1 | Use previous privilege for data accesses |
| prev_priv | input | 2 | Saved previous privilege level |
| vm_mode | input | VMW | Translation mode, 0 means none |
| dbg_mode | input | 1 | Core is in debug mode |
| vaddr | input | AW | Incoming address |
| walk_pbase | input | AW | Page-aligned result from the walker |
| walk_req | output | 1 | Access needs translation |
| walk_mode | output | 2 | Effective mode given to the walker |
| eff_mode | output | 2 | Effective mode (staged) |
| bypass | output | 1 | Translation bypassed (staged) |
| paddr | output | AW | Physical address (staged) |

## Verification
The hardest cases to reach are those where two overrides meet. One is a data access with `mod_priv` set while debug mode is active. The other is a bare translation mode, which must win over a non-machine previous privilege. The vector table places these next to plain cases. It also includes a machine-level core that uses `mod_priv` to drop to user mode, so the translated path is reached from machine level.

Several vectors also carry values that expose sloppy masking. Some have high address bits set above XLEN. Some have a walker result whose low 12 bits are nonzero. A directed test drives a change in mode between two clock edges and checks that only the combinational walker outputs have moved.

// File: rtl/xps_pkg.sv
package xps_pkg;
  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_OTHER = 2'd3
  } acc_e;

  localparam int PG_SHIFT = 12;
endpackage

// File: rtl/xps_mode_sel.sv
module xps_mode_sel
  import xps_pkg::*;
#(
  parameter int VMW = 5,
  parameter logic [VMW-1:0] VM_OFF = '0
) (
  input  logic [1:0]     acc_kind,
  input  logic [1:0]     cur_priv,
  input  logic           mod_priv,
  input  logic [1:0]     prev_priv,
  input  logic [VMW-1:0] vm_mode,
  input  logic           dbg_mode,
  output logic [1:0]     sel_mode
);
  logic is_data;
  logic take_prev;
  logic no_xlat;

  always_comb begin
    is_data   = (acc_kind != ACC_FETCH);
    take_prev = is_data && mod_priv && !dbg_mode;
    no_xlat   = (vm_mode == VM_OFF);
    if (no_xlat)        sel_mode = PRIV_M;
    else if (take_prev) sel_mode = prev_priv;
    else                sel_mode = cur_priv;
  end
endmodule

// File: rtl/xps_addr_join.sv
module xps_addr_join
  import xps_pkg::*;
#(
  parameter int AW   = 64,
  parameter int XLEN = 32,
  parameter int PGS  = 12
) (
  input  logic [1:0]    sel_mode,
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] walk_pbase,
  output logic          bypass,
  output logic          walk_req,
  output logic [AW-1:0] paddr
);
  localparam logic [AW-1:0] OFF_MASK = {{(AW-PGS){1'b0}}, {PGS{1'b1}}};

  logic [AW-1:0] xmask;

  generate
    if (XLEN < AW) begin : g_trunc
      assign xmask = {{(AW-XLEN){1'b0}}, {XLEN{1'b1}}};
    end else begin : g_full
      assign xmask = '1;
    end
  endgenerate

  always_comb begin
    bypass   = (sel_mode == PRIV_M);
    walk_req = !bypass;
    if (bypass) paddr = vaddr & xmask;
    else        paddr = (walk_pbase & ~OFF_MASK) | (vaddr & OFF_MASK);
  end
endmodule

// File: rtl/xps_out_stage.sv
module xps_out_stage #(
  parameter int W = 8,
  parameter bit REG_OUT = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/xlat_priv_sel.sv
module xlat_priv_sel
  import xps_pkg::*;
#(
  parameter int AW      = 64,
  parameter int XLEN    = 32,
  parameter int VMW     = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     acc_kind,
  input  logic [1:0]     cur_priv,
  input  logic           mod_priv,
  input  logic [1:0]     prev_priv,
  input  logic [VMW-1:0] vm_mode,
  input  logic           dbg_mode,
  input  logic [AW-1:0]  vaddr,
  input  logic [AW-1:0]  walk_pbase,
  output logic           walk_req,
  output logic [1:0]     walk_mode,
  output logic [1:0]     eff_mode,
  output logic           bypass,
  output logic [AW-1:0]  paddr
);
  localparam int SW = 2 + 1 + AW;
  localparam logic [SW-1:0] RST_VAL = {2'b11, 1'b1, {AW{1'b0}}};

  logic [1:0]    sel_mode;
  logic          nxt_bypass;
  logic [AW-1:0] nxt_paddr;
  logic [SW-1:0] stage_q;

  xps_mode_sel #(.VMW(VMW)) u_mode (
    .acc_kind (acc_kind),
    .cur_priv (cur_priv),
    .mod_priv (mod_priv),
    .prev_priv(prev_priv),
    .vm_mode  (vm_mode),
    .dbg_mode (dbg_mode),
    .sel_mode (sel_mode)
  );

  xps_addr_join #(.AW(AW), .XLEN(XLEN), .PGS(PG_SHIFT)) u_join (
    .sel_mode  (sel_mode),
    .vaddr     (vaddr),
    .walk_pbase(walk_pbase),
    .bypass    (nxt_bypass),
    .walk_req  (walk_req),
    .paddr     (nxt_paddr)
  );

  xps_out_stage #(.W(SW), .REG_OUT(REG_OUT), .RST_VAL(RST_VAL)) u_out (
    .clk(clk),
    .rst(rst),
    .d  ({sel_mode, nxt_bypass, nxt_paddr}),
    .q  (stage_q)
  );

  assign walk_mode = sel_mode;
  assign eff_mode  = stage_q[SW-1 -: 2];
  assign bypass    = stage_q[AW];
  assign paddr     = stage_q[AW-1:0];
endmodule

// File: rtl/xlat_priv_sel_chk.sv
module xlat_priv_sel_chk #(
  parameter int AW      = 64,
  parameter int XLEN    = 32,
  parameter int VMW     = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      acc_kind,
  input logic [1:0]      cur_priv,
  input logic            mod_priv,
  input logic [1:0]      prev_priv,
  input logic [VMW-1:0]  vm_mode,
  input logic            dbg_mode,
  input logic [XLEN-1:0] vaddr_x,
  input logic [1:0]      sel_mode,
  input logic [1:0]      eff_mode,
  input logic            bypass,
  input logic [AW-1:0]   paddr
);
  logic            d_ok;
  logic [XLEN-1:0] d_vx;
  logic [1:0]      d_sel;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
        d_ok  <= !rst;
        d_vx  <= vaddr_x;
        d_sel <= sel_mode;
      end
    end else begin : g_now
      assign d_ok  = 1'b1;
      assign d_vx  = vaddr_x;
      assign d_sel = sel_mode;
    end
  endgenerate

  assert_prev_used_R1: assert property (@(posedge clk) disable iff (rst)
    (acc_kind != 2'd0 && mod_priv && !dbg_mode && vm_mode != '0) |-> sel_mode == prev_priv);

  assert_fetch_cur_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'd0 && vm_mode != '0) |-> sel_mode == cur_priv);

  assert_debug_cur_R3: assert property (@(posedge clk) disable iff (rst)
    (dbg_mode && vm_mode != '0) |-> sel_mode == cur_priv);

  assert_bare_machine_R4: assert property (@(posedge clk) disable iff (rst)
    (vm_mode == '0) |-> sel_mode == 2'd3);

  assert_bypass_mode_R5: assert property (@(posedge clk) disable iff (rst)
    d_ok |-> bypass == (eff_mode == 2'd3));

  assert_bypass_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (d_ok && bypass) |-> paddr[XLEN-1:0] == d_vx);

  generate
    if (XLEN < AW) begin : g_hi
      assert_bypass_high_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (d_ok && bypass) |-> paddr[AW-1:XLEN] == '0);
    end
  endgenerate

  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (d_ok && !bypass) |-> paddr[11:0] == d_vx[11:0]);

  assert_stage_latency_R7: assert property (@(posedge clk) disable iff (rst)
    d_ok |-> eff_mode == d_sel);
endmodule

bind xlat_priv_sel xlat_priv_sel_chk #(
  .AW(AW), .XLEN(XLEN), .VMW(VMW), .REG_OUT(REG_OUT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_kind (acc_kind),
  .cur_priv (cur_priv),
  .mod_priv (mod_priv),
  .prev_priv(prev_priv),
  .vm_mode  (vm_mode),
  .dbg_mode (dbg_mode),
  .vaddr_x  (vaddr[XLEN-1:0]),
  .sel_mode (sel_mode),
  .eff_mode (eff_mode),
  .bypass   (bypass),
  .paddr    (paddr)
);

// File: tb/tb_xlat_priv_sel.sv
`timescale 1ns/1ps
module tb_xlat_priv_sel;
  typedef struct packed {
    logic [1:0]  acc;
    logic [1:0]  cur;
    logic        mp;
    logic [1:0]  prv;
    logic [4:0]  vm;
    logic        dbg;
    logic [63:0] va;
    logic [63:0] wb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b1, 2'd3, 5'd8, 1'b0, 64'h0000_0000_1234_5ABC, 64'h0000_0000_8765_4FFF},
    '{2'd1, 2'd0, 1'b1, 2'd1, 5'd8, 1'b0, 64'h0000_0000_0000_1777, 64'h0000_00AB_CDEF_0000},
    '{2'd2, 2'd1, 1'b1, 2'd3, 5'd8, 1'b0, 64'hFFFF_FFFF_DEAD_BEEF, 64'h0000_0000_1111_1000},
    '{2'd1, 2'd3, 1'b1, 2'd0, 5'd8, 1'b1, 64'h0000_0001_CAFE_F00D, 64'h0000_0000_2222_2000},
    '{2'd2, 2'd1, 1'b0, 2'd3, 5'd8, 1'b0, 64'h0000_0000_0040_0123, 64'h0000_0000_3333_3456},
    '{2'd0, 2'd0, 1'b0, 2'd0, 5'd0, 1'b0, 64'hABCD_0000_0000_0042, 64'h0000_0000_4444_4000},
    '{2'd1, 2'd1, 1'b1, 2'd0, 5'd0, 1'b0, 64'h0000_0010_8000_0FFF, 64'h0000_0000_5555_5000},
    '{2'd0, 2'd1, 1'b0, 2'd3, 5'd9, 1'b1, 64'h0000_0000_0000_0ABC, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd2, 2'd3, 1'b1, 2'd0, 5'd8, 1'b0, 64'h0000_0000_7654_3210, 64'h0000_0000_9999_9000},
    '{2'd1, 2'd3, 1'b0, 2'd0, 5'd8, 1'b0, 64'h0000_0001_0000_0000, 64'h0000_0000_6666_6000},
    '{2'd3, 2'd0, 1'b1, 2'd1, 5'd8, 1'b0, 64'h0000_0000_0000_0FED, 64'h0000_1234_0000_0000},
    '{2'd0, 2'd3, 1'b1, 2'd0, 5'd8, 1'b0, 64'h8000_0000_FFFF_FFFF, 64'h0000_0000_7777_7000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_kind = '0;
  logic [1:0]  cur_priv = '0;
  logic        mod_priv = 1'b0;
  logic [1:0]  prev_priv = '0;
  logic [4:0]  vm_mode = '0;
  logic        dbg_mode = 1'b0;
  logic [63:0] vaddr = '0;
  logic [63:0] walk_pbase = '0;
  logic        walk_req;
  logic [1:0]  walk_mode;
  logic [1:0]  eff_mode;
  logic        bypass;
  logic [63:0] paddr;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xlat_priv_sel dut (
    .clk(clk), .rst(rst), .acc_kind(acc_kind), .cur_priv(cur_priv),
    .mod_priv(mod_priv), .prev_priv(prev_priv), .vm_mode(vm_mode),
    .dbg_mode(dbg_mode), .vaddr(vaddr), .walk_pbase(walk_pbase),
    .walk_req(walk_req), .walk_mode(walk_mode), .eff_mode(eff_mode),
    .bypass(bypass), .paddr(paddr)
  );

  function automatic logic [1:0] mdl_mode(vec_t v);
    logic [1:0] m;
    m = (v.acc != 2'd0 && v.mp && !v.dbg) ? v.prv : v.cur;
    if (v.vm == 5'd0) m = 2'd3;
    return m;
  endfunction

  function automatic logic [63:0] mdl_paddr(vec_t v);
    if (mdl_mode(v) == 2'd3) return v.va & 64'h0000_0000_FFFF_FFFF;
    return (v.wb & ~64'hFFF) | (v.va & 64'hFFF);
  endfunction

  function automatic string mode_tag(vec_t v);
    if (v.vm == 5'd0) return "R4";
    if (v.acc == 2'd0) return "R2";
    if (v.dbg) return "R3";
    return "R1";
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    acc_kind = v.acc; cur_priv = v.cur; mod_priv = v.mp; prev_priv = v.prv;
    vm_mode = v.vm; dbg_mode = v.dbg; vaddr = v.va; walk_pbase = v.wb;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 50000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    apply(VECS[1]);
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset mode", 64'(eff_mode), 64'd3);
    chk("R7 reset bypass", 64'(bypass), 64'd1);
    chk("R7 reset addr", paddr, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #1;
      if (mdl_mode(VECS[i]) == 2'd3) begin
        chk("R5 walk_req low", 64'(walk_req), 64'd0);
      end else begin
        chk("R6 walk_req high", 64'(walk_req), 64'd1);
        chk("R6 walk_mode", 64'(walk_mode), 64'(mdl_mode(VECS[i])));
      end
      @(posedge clk);
      #1;
      chk(mode_tag(VECS[i]), 64'(eff_mode), 64'(mdl_mode(VECS[i])));
      chk(mdl_mode(VECS[i]) == 2'd3 ? "R5 bypass" : "R6 bypass",
          64'(bypass), 64'(mdl_mode(VECS[i]) == 2'd3));
      chk(mdl_mode(VECS[i]) == 2'd3 ? "R5 paddr" : "R6 paddr",
          paddr, mdl_paddr(VECS[i]));
    end

    // R7: mode change between edges moves only the walker outputs
    @(negedge clk);
    apply(VECS[0]);
    @(posedge clk);
    @(negedge clk);
    apply(VECS[2]);
    #1;
    chk("R7 eff_mode held", 64'(eff_mode), 64'd0);
    chk("R7 bypass held", 64'(bypass), 64'd0);
    chk("R7 walk_req now", 64'(walk_req), 64'd0);
    @(posedge clk);
    #1;
    chk("R7 eff_mode after edge", 64'(eff_mode), 64'd3);
    chk("R7 paddr after edge", paddr, 64'h0000_0000_DEAD_BEEF);

    // R3: debug with store and supervisor previous level keeps user
    @(negedge clk);
    apply('{2'd2, 2'd0, 1'b1, 2'd1, 5'd8, 1'b1, 64'h0000_0000_0000_0123, 64'h0000_0000_ABC0_0000});
    @(posedge clk);
    #1;
    chk("R3 debug store", 64'(eff_mode), 64'd0);
    chk("R6 debug store paddr", paddr, 64'h0000_0000_ABC0_0123);

    finish_run();
  end
endmodule